// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits between the host write port of a NOR-style flash device and its internal write engine. On every host write cycle it looks at the low byte of the data bus as a command code and the address bus as a word address. Single-cycle codes select what the read path returns: array data, the status byte, identifier data or query data. Two-cycle codes first arm a setup state. The second write then confirms the sequence and issues a request to the write engine, or it is rejected with a sequence error.

The write engine is modelled as a running flag that the decoder sets when it issues a program or erase. A one-cycle done pulse from the engine clears it. While a program runs, the decoder reacts only to the suspend code. While an erase runs, it also accepts read-mode and clear-status codes. While an operation is suspended, it accepts reads, clear-status and resume. The status byte is frozen into an output latch when output enable and chip enable are both low for the first cycle, so that a poll sees a steady value.

Top module: `fci_cmd_top`

## Requirements
- R1: After reset, read_mode is 0 (array), op_valid is 0, cfg_reg is 0, and the status byte reads 80h. Status bit 7 = ready, bit 6 = suspended, bit 4 = sequence error, and all other bits are 0.
- R2: When not blocked by a running program, the codes FFh, 70h, 90h and 98h set read_mode to 0 (array), 1 (status), 2 (identifier) and 3 (query), one cycle after the write.
- R3: 20h followed by D0h to an address in the same block (address bits above BLK_SHIFT equal) pulses op_valid for one cycle with op_kind 1 (erase) and op_addr equal to the setup address, and marks the engine running. Any other second write sets status bit 4, issues nothing and returns to idle.
- R4: 40h or 10h followed by any write pulses op_kind 2 (program), with op_addr and op_data taken from the second write, and marks the engine running.
- R5: After 60h, a second code of 01h, D0h or 2Fh issues op_kind 5 (lock), 6 (unlock) or 7 (lock down) with the second write's address. 03h loads cfg_reg from address bits CFG_W-1:0 and issues nothing. Any other code sets status bit 4.
- R6: After C0h, a second write to PROT_LOCK_ADDR issues op_kind 9 (protection lock) without marking the engine running. A write to any other address issues op_kind 8 (protection program), carrying the address and data, and marks it running.
- R7: While a program runs, B0h issues op_kind 3 (suspend), sets status bit 6 and shows ready. Every other write changes no output.
- R8: While an erase runs, B0h suspends it. Read-mode codes and 50h act as usual, and setup codes (20h, 40h, 10h, 60h, C0h) are ignored.
- R9: While suspended, D0h issues op_kind 4 (resume), clears bit 6 and marks the engine running again. Setup codes and B0h are ignored.
- R10: A wsm_done pulse while the engine is running makes status bit 7 read 1 again. It has no effect otherwise.
- R11: Every second write of a two-cycle sequence, every setup write, every suspend and every resume leaves read_mode at 1 (status). read_mode changes only on a write.
- R12: 50h clears status bit 4 whenever the decoder is not blocked by a running program.
- R13: rd_status equals {00h, status byte}, captured on the first cycle in which rd_oe_n and rd_ce_n are both low. It holds while both stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One-cycle host write strobe |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | DATA_W | Write data; bits 7:0 carry the command code |
| wsm_done | input | 1 | Write engine finished its operation |
| rd_oe_n | input | 1 | Output enable, active low |
| rd_ce_n | input | 1 | Chip enable, active low |
| op_valid | output | 1 | One-cycle request to the write engine |
| op_kind | output | 4 | Request code (see R3 to R9) |
| op_addr | output | ADDR_W | Request address |
| op_data | output | DATA_W | Request data |
| read_mode | output | 2 | Current read source |
| cfg_reg | output | CFG_W | Read configuration value |
| rd_status | output | DATA_W | Latched status word |

## Verification
The assertions assume that wsm_done and wr_en are never high in the same cycle, and that wsm_done arrives only as a single-cycle pulse. The bench keeps to this by driving done pulses in cycles of their own, between writes. Random stimulus draws command codes mostly from the defined set, plus arbitrary bytes, to addresses in two blocks and at the protection-lock address. A bench model predicts every request, mode change and status value.

// File: rtl/fci_pkg.sv
package fci_pkg;
   localparam logic [7:0] CMD_RD_ARRAY = 8'hFF;
   localparam logic [7:0] CMD_RD_IDENT = 8'h90;
   localparam logic [7:0] CMD_RD_STAT  = 8'h70;
   localparam logic [7:0] CMD_RD_QUERY = 8'h98;
   localparam logic [7:0] CMD_CLR_STAT = 8'h50;
   localparam logic [7:0] CMD_ERS_SET  = 8'h20;
   localparam logic [7:0] CMD_PGM_SET  = 8'h40;
   localparam logic [7:0] CMD_PGM_ALT  = 8'h10;
   localparam logic [7:0] CMD_LCK_SET  = 8'h60;
   localparam logic [7:0] CMD_PROT_SET = 8'hC0;
   localparam logic [7:0] CMD_SUSPEND  = 8'hB0;
   localparam logic [7:0] CMD_CONFIRM  = 8'hD0;
   localparam logic [7:0] CMD_LOCK     = 8'h01;
   localparam logic [7:0] CMD_LOCKDN   = 8'h2F;
   localparam logic [7:0] CMD_CFG      = 8'h03;

   typedef enum logic [1:0] {
      RM_ARRAY  = 2'd0,
      RM_STATUS = 2'd1,
      RM_IDENT  = 2'd2,
      RM_QUERY  = 2'd3
   } fci_rmode_e;

   typedef enum logic [3:0] {
      OP_NONE     = 4'd0,
      OP_ERASE    = 4'd1,
      OP_PROGRAM  = 4'd2,
      OP_SUSPEND  = 4'd3,
      OP_RESUME   = 4'd4,
      OP_LOCK     = 4'd5,
      OP_UNLOCK   = 4'd6,
      OP_LOCKDOWN = 4'd7,
      OP_PROT_PGM = 4'd8,
      OP_PROT_LCK = 4'd9
   } fci_op_e;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_ERS  = 3'd1,
      ST_PGM  = 3'd2,
      ST_LCK  = 3'd3,
      ST_PROT = 3'd4
   } fci_state_e;
endpackage

// File: rtl/fci_cmd_decode.sv
module fci_cmd_decode
   import fci_pkg::*;
#(
   parameter int ADDR_W = 21,
   parameter int DATA_W = 16,
   parameter int BLK_SHIFT = 15,
   parameter int CFG_W = 16,
   parameter bit CHECK_BLOCK = 1'b1,
   parameter logic [ADDR_W-1:0] PROT_LOCK_ADDR = 'h80
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wsm_done,
   output logic              op_valid,
   output fci_op_e           op_kind,
   output logic [ADDR_W-1:0] op_addr,
   output logic [DATA_W-1:0] op_data,
   output fci_rmode_e        read_mode,
   output logic [CFG_W-1:0]  cfg_reg,
   output logic              running,
   output logic              suspended,
   output logic              seq_err
);
   fci_state_e        state_q, state_d;
   logic [ADDR_W-1:0] saddr_q, saddr_d;
   logic              run_q, run_d, ers_q, ers_d, susp_q, susp_d, err_q, err_d;
   fci_rmode_e        mode_q, mode_d;
   logic [CFG_W-1:0]  cfg_q, cfg_d;
   logic              opv_q, opv_d;
   fci_op_e           opk_q, opk_d;
   logic [ADDR_W-1:0] opa_q, opa_d;
   logic [DATA_W-1:0] opd_q, opd_d;
   logic [7:0]        cmd;
   logic              blk_match, blocked;

   assign cmd = wr_data[7:0];

   generate
      if (CHECK_BLOCK) begin : g_blk_check
         assign blk_match = (wr_addr[ADDR_W-1:BLK_SHIFT] == saddr_q[ADDR_W-1:BLK_SHIFT]);
      end else begin : g_blk_any
         assign blk_match = 1'b1;
      end
   endgenerate

   assign blocked = run_q | susp_q;

   always_comb begin
      state_d = state_q;
      saddr_d = saddr_q;
      run_d   = run_q & ~wsm_done;
      ers_d   = ers_q;
      susp_d  = susp_q;
      err_d   = err_q;
      mode_d  = mode_q;
      cfg_d   = cfg_q;
      opv_d   = 1'b0;
      opk_d   = OP_NONE;
      opa_d   = wr_addr;
      opd_d   = wr_data;
      if (wr_en) begin
         if (state_q != ST_IDLE) begin
            state_d = ST_IDLE;
            mode_d  = RM_STATUS;
            unique case (state_q)
               ST_ERS: begin
                  if (cmd == CMD_CONFIRM && blk_match) begin
                     opv_d = 1'b1; opk_d = OP_ERASE; opa_d = saddr_q;
                     run_d = 1'b1; ers_d = 1'b1;
                  end else begin
                     err_d = 1'b1;
                  end
               end
               ST_PGM: begin
                  opv_d = 1'b1; opk_d = OP_PROGRAM;
                  run_d = 1'b1; ers_d = 1'b0;
               end
               ST_LCK: begin
                  unique case (cmd)
                     CMD_LOCK:    begin opv_d = 1'b1; opk_d = OP_LOCK;     end
                     CMD_CONFIRM: begin opv_d = 1'b1; opk_d = OP_UNLOCK;   end
                     CMD_LOCKDN:  begin opv_d = 1'b1; opk_d = OP_LOCKDOWN; end
                     CMD_CFG:     cfg_d = wr_addr[CFG_W-1:0];
                     default:     err_d = 1'b1;
                  endcase
               end
               ST_PROT: begin
                  opv_d = 1'b1;
                  if (wr_addr == PROT_LOCK_ADDR) begin
                     opk_d = OP_PROT_LCK;
                  end else begin
                     opk_d = OP_PROT_PGM; run_d = 1'b1; ers_d = 1'b0;
                  end
               end
               default: ;
            endcase
         end else if (run_q && !ers_q) begin
            if (cmd == CMD_SUSPEND) begin
               opv_d = 1'b1; opk_d = OP_SUSPEND;
               run_d = 1'b0; susp_d = 1'b1; mode_d = RM_STATUS;
            end
         end else begin
            unique case (cmd)
               CMD_RD_ARRAY: mode_d = RM_ARRAY;
               CMD_RD_STAT:  mode_d = RM_STATUS;
               CMD_RD_IDENT: mode_d = RM_IDENT;
               CMD_RD_QUERY: mode_d = RM_QUERY;
               CMD_CLR_STAT: err_d  = 1'b0;
               CMD_SUSPEND: begin
                  if (run_q) begin
                     opv_d = 1'b1; opk_d = OP_SUSPEND;
                     run_d = 1'b0; susp_d = 1'b1; mode_d = RM_STATUS;
                  end
               end
               CMD_CONFIRM: begin
                  if (susp_q) begin
                     opv_d = 1'b1; opk_d = OP_RESUME;
                     run_d = 1'b1; susp_d = 1'b0; mode_d = RM_STATUS;
                  end
               end
               CMD_ERS_SET: begin
                  if (!blocked) begin
                     state_d = ST_ERS; saddr_d = wr_addr; mode_d = RM_STATUS;
                  end
               end
               CMD_PGM_SET, CMD_PGM_ALT: begin
                  if (!blocked) begin state_d = ST_PGM; mode_d = RM_STATUS; end
               end
               CMD_LCK_SET: begin
                  if (!blocked) begin state_d = ST_LCK; mode_d = RM_STATUS; end
               end
               CMD_PROT_SET: begin
                  if (!blocked) begin state_d = ST_PROT; mode_d = RM_STATUS; end
               end
               default: ;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         saddr_q <= '0;
         run_q   <= 1'b0;
         ers_q   <= 1'b0;
         susp_q  <= 1'b0;
         err_q   <= 1'b0;
         mode_q  <= RM_ARRAY;
         cfg_q   <= '0;
         opv_q   <= 1'b0;
         opk_q   <= OP_NONE;
         opa_q   <= '0;
         opd_q   <= '0;
      end else begin
         state_q <= state_d;
         saddr_q <= saddr_d;
         run_q   <= run_d;
         ers_q   <= ers_d;
         susp_q  <= susp_d;
         err_q   <= err_d;
         mode_q  <= mode_d;
         cfg_q   <= cfg_d;
         opv_q   <= opv_d;
         opk_q   <= opk_d;
         opa_q   <= opa_d;
         opd_q   <= opd_d;
      end
   end

   assign op_valid  = opv_q;
   assign op_kind   = opk_q;
   assign op_addr   = opa_q;
   assign op_data   = opd_q;
   assign read_mode = mode_q;
   assign cfg_reg   = cfg_q;
   assign running   = run_q;
   assign suspended = susp_q;
   assign seq_err   = err_q;

   // R3: an erase request only follows a confirm written in the erase setup state
   p_erase_confirm_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (opv_q && opk_q == OP_ERASE) |-> $past(wr_en && state_q == ST_ERS && wr_data[7:0] == CMD_CONFIRM));
   // R3: the error bit rises only because of a host write
   p_err_by_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_q) |-> $past(wr_en));
   // R7: a running program answers nothing but suspend
   p_pgm_lockout_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && run_q && !ers_q && state_q == ST_IDLE && wr_data[7:0] != CMD_SUSPEND) |=> !opv_q);
   // R9: a suspended operation is never running at the same time
   p_susp_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      susp_q |-> !run_q);
   // R11: read mode moves only on a host write
   p_mode_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(mode_q));
endmodule

// File: rtl/fci_status_port.sv
module fci_status_port #(
   parameter int DATA_W = 16,
   parameter bit LATCH_STATUS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              running,
   input  logic              suspended,
   input  logic              seq_err,
   input  logic              rd_oe_n,
   input  logic              rd_ce_n,
   output logic [DATA_W-1:0] rd_status
);
   localparam int PAD_W = DATA_W - 8;

   logic [7:0] stat_byte;
   logic       sel, sel_q, capture;

   assign stat_byte = {~running, suspended, 1'b0, seq_err, 4'b0000};
   assign sel       = ~rd_oe_n & ~rd_ce_n;
   assign capture   = sel & ~sel_q;

   always_ff @(posedge clk) begin
      if (!rst_n) sel_q <= 1'b0;
      else        sel_q <= sel;
   end

   generate
      if (LATCH_STATUS) begin : g_latched
         logic [7:0] hold_q;
         always_ff @(posedge clk) begin
            if (!rst_n)       hold_q <= 8'h80;
            else if (capture) hold_q <= stat_byte;
         end
         assign rd_status = {{PAD_W{1'b0}}, hold_q};
         // R13: the latched byte stays put while the read stays selected
         p_latch_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
            (sel && sel_q) |=> $stable(hold_q));
      end else begin : g_live
         assign rd_status = {{PAD_W{1'b0}}, stat_byte};
      end
   endgenerate

   // R8: suspension always reads as ready
   p_susp_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
      suspended |-> stat_byte[7]);
endmodule

// File: rtl/fci_cmd_top.sv
module fci_cmd_top
   import fci_pkg::*;
#(
   parameter int ADDR_W = 21,
   parameter int DATA_W = 16,
   parameter int BLK_SHIFT = 15,
   parameter int CFG_W = 16,
   parameter bit CHECK_BLOCK = 1'b1,
   parameter bit LATCH_STATUS = 1'b1,
   parameter logic [ADDR_W-1:0] PROT_LOCK_ADDR = 'h80
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wsm_done,
   input  logic              rd_oe_n,
   input  logic              rd_ce_n,
   output logic              op_valid,
   output logic [3:0]        op_kind,
   output logic [ADDR_W-1:0] op_addr,
   output logic [DATA_W-1:0] op_data,
   output logic [1:0]        read_mode,
   output logic [CFG_W-1:0]  cfg_reg,
   output logic [DATA_W-1:0] rd_status
);
   if (DATA_W < 16) begin : g_bad_data
      $error("fci_cmd_top: DATA_W must be at least 16");
   end
   if (BLK_SHIFT < 1 || BLK_SHIFT >= ADDR_W) begin : g_bad_blk
      $error("fci_cmd_top: BLK_SHIFT must lie inside the address");
   end
   if (CFG_W < 1 || CFG_W > ADDR_W) begin : g_bad_cfg
      $error("fci_cmd_top: CFG_W must fit in the address");
   end

   fci_op_e    kind_w;
   fci_rmode_e mode_w;
   logic       running_w, susp_w, err_w;

   fci_cmd_decode #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_SHIFT(BLK_SHIFT), .CFG_W(CFG_W),
      .CHECK_BLOCK(CHECK_BLOCK), .PROT_LOCK_ADDR(PROT_LOCK_ADDR)
   ) u_decode (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .wsm_done(wsm_done), .op_valid(op_valid), .op_kind(kind_w), .op_addr(op_addr),
      .op_data(op_data), .read_mode(mode_w), .cfg_reg(cfg_reg),
      .running(running_w), .suspended(susp_w), .seq_err(err_w)
   );

   fci_status_port #(.DATA_W(DATA_W), .LATCH_STATUS(LATCH_STATUS)) u_status (
      .clk(clk), .rst_n(rst_n), .running(running_w), .suspended(susp_w), .seq_err(err_w),
      .rd_oe_n(rd_oe_n), .rd_ce_n(rd_ce_n), .rd_status(rd_status)
   );

   assign op_kind   = kind_w;
   assign read_mode = mode_w;

   // R1: the request strobe is a single-cycle pulse for a single write
   p_pulse_once_r1: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |=> !op_valid);
endmodule

// File: tb/fci_cmd_top_tb_top.sv
module fci_cmd_top_tb_top;
   localparam int AW = 21;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic          wsm_done = 1'b0;
   logic          rd_oe_n = 1'b1;
   logic          rd_ce_n = 1'b0;
   logic          op_valid;
   logic [3:0]    op_kind;
   logic [AW-1:0] op_addr;
   logic [DW-1:0] op_data;
   logic [1:0]    read_mode;
   logic [15:0]   cfg_reg;
   logic [DW-1:0] rd_status;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 0;

   int m_st = 0;
   bit m_run = 0, m_ers = 0, m_susp = 0, m_err = 0;
   int m_mode = 0;
   logic [15:0] m_cfg = '0;
   logic [AW-1:0] m_sa = '0;
   bit e_v;
   int e_k;
   logic [AW-1:0] e_a;
   logic [DW-1:0] e_d;

   always #2 clk = ~clk;

   fci_cmd_top dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .wsm_done(wsm_done), .rd_oe_n(rd_oe_n), .rd_ce_n(rd_ce_n), .op_valid(op_valid),
      .op_kind(op_kind), .op_addr(op_addr), .op_data(op_data), .read_mode(read_mode),
      .cfg_reg(cfg_reg), .rd_status(rd_status)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_status();
      return {~m_run, m_susp, 1'b0, m_err, 4'b0000};
   endfunction

   function automatic bit is_setup(input logic [7:0] c);
      return c == 8'h20 || c == 8'h40 || c == 8'h10 || c == 8'h60 || c == 8'hC0;
   endfunction

   task automatic model_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      logic [7:0] c = d[7:0];
      int st;
      e_v = 0; e_k = 0; e_a = a; e_d = d;
      if (m_st != 0) begin
         st = m_st; m_st = 0; m_mode = 1;
         case (st)
            1: if (c == 8'hD0 && a[AW-1:15] == m_sa[AW-1:15]) begin
                  e_v = 1; e_k = 1; e_a = m_sa; m_run = 1; m_ers = 1;
               end else m_err = 1;
            2: begin e_v = 1; e_k = 2; m_run = 1; m_ers = 0; end
            3: case (c)
                  8'h01: begin e_v = 1; e_k = 5; end
                  8'hD0: begin e_v = 1; e_k = 6; end
                  8'h2F: begin e_v = 1; e_k = 7; end
                  8'h03: m_cfg = a[15:0];
                  default: m_err = 1;
               endcase
            default: begin
               e_v = 1;
               if (a == 'h80) e_k = 9;
               else begin e_k = 8; m_run = 1; m_ers = 0; end
            end
         endcase
      end else if (m_run && !m_ers) begin
         if (c == 8'hB0) begin e_v = 1; e_k = 3; m_run = 0; m_susp = 1; m_mode = 1; end
      end else begin
         if (c == 8'hFF) m_mode = 0;
         else if (c == 8'h70) m_mode = 1;
         else if (c == 8'h90) m_mode = 2;
         else if (c == 8'h98) m_mode = 3;
         else if (c == 8'h50) m_err = 0;
         else if (c == 8'hB0) begin
            if (m_run) begin e_v = 1; e_k = 3; m_run = 0; m_susp = 1; m_mode = 1; end
         end else if (c == 8'hD0) begin
            if (m_susp) begin e_v = 1; e_k = 4; m_run = 1; m_susp = 0; m_mode = 1; end
         end else if (is_setup(c) && !m_run && !m_susp) begin
            m_mode = 1;
            if (c == 8'h20) begin m_st = 1; m_sa = a; end
            else if (c == 8'h60) m_st = 3;
            else if (c == 8'hC0) m_st = 4;
            else m_st = 2;
         end
      end
   endtask

   task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input string req);
      @(negedge clk);
      wr_en = 1; wr_addr = a; wr_data = d;
      model_write(a, d);
      @(negedge clk);
      wr_en = 0;
      chk(op_valid == e_v, {req, " op_valid"}, op_valid, e_v);
      if (e_v) begin
         chk(op_kind == 4'(e_k), {req, " op_kind"}, op_kind, e_k);
         chk(op_addr == e_a, {req, " op_addr"}, op_addr, e_a);
         if (e_k == 2 || e_k == 8) chk(op_data == e_d, {req, " op_data"}, op_data, e_d);
      end
      chk(read_mode == 2'(m_mode), {req, " read_mode"}, read_mode, m_mode);
      chk(cfg_reg == m_cfg, {req, " cfg_reg"}, cfg_reg, m_cfg);
   endtask

   task automatic do_done(input string req);
      @(negedge clk);
      wsm_done = 1;
      m_run = 0;
      @(negedge clk);
      wsm_done = 0;
      chk(op_valid == 0, {req, " no op on done"}, op_valid, 0);
   endtask

   task automatic read_status(input string req);
      logic [DW-1:0] exp;
      @(negedge clk); rd_oe_n = 1;
      @(negedge clk); rd_oe_n = 0;
      exp = {8'h00, exp_status()};
      @(negedge clk);
      chk(rd_status == exp, {req, " rd_status"}, rd_status, exp);
   endtask

   task automatic chk_status(input logic [7:0] lit, input string req);
      read_status(req);
      chk(rd_status == {8'h00, lit}, {req, " status literal"}, rd_status, lit);
   endtask

   initial begin
      #(4 * 150000);
      if (!finished) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog actual=running expected=done");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] held;
      void'($urandom(32'd1957));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(read_mode == 0, "R1 read_mode", read_mode, 0);
      chk(op_valid == 0, "R1 op_valid", op_valid, 0);
      chk(cfg_reg == 0, "R1 cfg_reg", cfg_reg, 0);
      chk_status(8'h80, "R1");
      // R2 read modes
      do_write('h10, 16'h0070, "R2 status");
      do_write('h10, 16'h0098, "R2 query");
      do_write('h10, 16'h0090, "R2 ident");
      do_write('h10, 16'h00FF, "R2 array");
      // R3 erase, R11 status mode
      do_write('h00100, 16'h0020, "R11 setup");
      do_write('h00200, 16'h00D0, "R3 erase");
      chk_status(8'h00, "R3 busy");
      // R8 erase running
      do_write('h0, 16'h0040, "R8 setup ignored");
      do_write('h0, 16'h0098, "R8 read query");
      do_write('h0, 16'h00B0, "R8 suspend");
      chk_status(8'hC0, "R8");
      // R9 suspended
      do_write('h0, 16'h0020, "R9 setup ignored");
      do_write('h0, 16'h00B0, "R9 suspend ignored");
      do_write('h0, 16'h00D0, "R9 resume");
      chk_status(8'h00, "R9");
      // R10 done
      do_done("R10");
      chk_status(8'h80, "R10");
      do_done("R10 idle done");
      // R3 bad block, bad code
      do_write('h00100, 16'h0020, "R3 setup");
      do_write('h08100, 16'h00D0, "R3 other block");
      chk_status(8'h90, "R3 seq err");
      do_write('h0, 16'h0050, "R12 clear");
      chk_status(8'h80, "R12");
      do_write('h00100, 16'h0020, "R3 setup");
      do_write('h00100, 16'h00FF, "R3 bad code");
      do_write('h0, 16'h0050, "R12 clear");
      // R4 program and R7 lockout
      do_write('h0, 16'h0040, "R4 setup");
      do_write('h01234, 16'hBEEF, "R4 program");
      do_write('h0, 16'h00FF, "R7 ignored");
      do_write('h0, 16'h0020, "R7 ignored setup");
      do_write('h0, 16'h00B0, "R7 suspend");
      chk_status(8'hC0, "R7");
      do_write('h0, 16'h00D0, "R9 resume pgm");
      do_done("R10");
      do_write('h0, 16'h0010, "R4 alt setup");
      do_write('h0ABCD, 16'h1357, "R4 alt program");
      do_done("R10");
      // R5 locking and configuration
      do_write('h08000, 16'h0060, "R5 setup");
      do_write('h08001, 16'h0001, "R5 lock");
      do_write('h08000, 16'h0060, "R5 setup");
      do_write('h08002, 16'h00D0, "R5 unlock");
      do_write('h08000, 16'h0060, "R5 setup");
      do_write('h08003, 16'h002F, "R5 lockdown");
      do_write('h0, 16'h0060, "R5 setup");
      do_write('h00ABC, 16'h0003, "R5 cfg");
      chk(cfg_reg == 16'h0ABC, "R5 cfg literal", cfg_reg, 16'h0ABC);
      do_write('h0, 16'h0060, "R5 setup");
      do_write('h0, 16'h0077, "R5 bad code");
      chk_status(8'h90, "R5");
      // R6 protection
      do_write('h0, 16'h00C0, "R6 setup");
      do_write('h80, 16'h0000, "R6 prot lock");
      chk_status(8'h90, "R6 no busy");
      do_write('h0, 16'h00C0, "R6 setup");
      do_write('h81, 16'h5555, "R6 prot program");
      chk_status(8'h10, "R6 busy");
      do_done("R10");
      do_write('h0, 16'h0050, "R12 clear");
      // R13 latch holds while selected
      read_status("R13 capture");
      held = rd_status[7:0];
      do_write('h0, 16'h0020, "R13 setup");
      do_write('h0, 16'h0011, "R13 bad confirm");
      chk(rd_status == {8'h00, held}, "R13 held", rd_status, held);
      read_status("R13 recapture");
      @(negedge clk); rd_ce_n = 1;
      do_write('h0, 16'h0050, "R12 clear");
      @(negedge clk); rd_ce_n = 0;
      @(negedge clk);
      chk(rd_status == 16'h0080, "R13 ce capture", rd_status, 16'h0080);
      // random mix
      for (int i = 0; i < 600; i++) begin
         int pick = $urandom % 20;
         logic [7:0] codes [16] = '{8'hFF, 8'h90, 8'h70, 8'h98, 8'h50, 8'h20, 8'h40, 8'h10,
                                    8'h60, 8'hC0, 8'hB0, 8'hD0, 8'h01, 8'h2F, 8'h03, 8'h00};
         logic [AW-1:0] a;
         logic [DW-1:0] d;
         case ($urandom % 4)
            0: a = 'h00010;
            1: a = 'h08020;
            2: a = 'h00080;
            default: a = AW'($urandom);
         endcase
         d = DW'($urandom);
         if (pick < 15) d[7:0] = codes[pick];
         else if (pick < 17) d[7:0] = codes[$urandom % 16];
         if ($urandom % 6 == 0) do_done("RAND done");
         else if ($urandom % 8 == 0) read_status("RAND status");
         else do_write(a, d, "RAND");
      end
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule